// File: doc/BRIEF.md
# Qualified Valley Pulse Detector

This block sits in the timing path of a quasi-resonant switching controller. It receives two comparator flags that watch the divided auxiliary-winding voltage: an arming flag for a higher threshold and a valley flag for a lower threshold. It also receives the controller's own gate-drive signal. From these it produces a single-clock pulse for each ringing valley that is worth switching on. A crossing only counts if three things hold. The node must first have risen past the arming threshold. The downward crossing must land outside a blanking window that follows switch turn-off. Once accepted, the crossing is still held back by a fixed delay before the pulse is issued, so that the switch turns on near the bottom of the swing rather than at the threshold.

Both comparator flags are brought into the clock domain through a synchronizer chain. The gate signal is routed through the same chain, so every window and delay is measured between input events as seen at the pins. All durations are parameters counted in clock cycles. The defaults (a 25-cycle delay and a 100-cycle mask) correspond to 500 ns and 2 µs at 50 MHz. Each arming allows at most one valley. A new gate pulse discards both the arming and any valley still waiting out its delay.

Top module: `valley_qualifier`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `valley_o` is low. A valley still waiting out its delay when reset is applied is discarded and never produces a pulse.
- R2: An accepted valley makes `valley_o` high for exactly one clock cycle. The pulse starts at the rising edge DELAY_CYC+SYNC_STAGES edges after the edge that first samples `vly_cmp_i` low. `vly_cmp_i` = 1 means the node is above the lower threshold, and a valley is its 1-to-0 transition.
- R3: A falling crossing produces no pulse unless `arm_cmp_i` (1 = node above the higher threshold) was sampled high at some edge before the crossing edge, and after both the last consumed crossing and the last gate rise.
- R4: Let d be the number of edges from the edge that first samples `gate_i` low to the edge that first samples `vly_cmp_i` low. With d <= MASK_CYC the crossing is masked and gives no pulse. With d = MASK_CYC+1 or more, an armed crossing gives a pulse.
- R5: A falling crossing that is sampled while `gate_i` is high gives no pulse.
- R6: Any falling crossing clears the arming, whether it was accepted or masked. A later crossing gives no pulse unless the node is armed again.
- R7: A rising edge on `gate_i` clears the arming, so a node armed before a gate pulse cannot yield a valley after that pulse.
- R8: Suppose `gate_i` is first sampled high at edge R while a valley is pending from a crossing at edge V. If R <= V+DELAY_CYC, the pending valley is cancelled. If R = V+DELAY_CYC+1, the pulse still appears.
- R9: If a second crossing is accepted while an earlier one is still pending, the earlier one is dropped. Exactly one pulse follows, timed from the second crossing as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_cmp_i | input | 1 | Higher-threshold comparator, 1 = node above the arming level |
| vly_cmp_i | input | 1 | Lower-threshold comparator, 1 = node above the valley level |
| gate_i | input | 1 | Gate drive, 1 = switch on; its falling edge opens the mask window |
| valley_o | output | 1 | Registered one-cycle valley pulse |

## Verification
A stuck or stale arming flag shows as a pulse after a crossing that had no arming. That pulse appears exactly DELAY_CYC+SYNC_STAGES cycles after the crossing, so the stimulus places unarmed crossings after masked crossings, after accepted crossings and after gate pulses. An off-by-one in the mask counter only shows when the gap is exactly MASK_CYC or MASK_CYC+1, so both gaps are driven. A pending delay that survives a gate rise, reset or a restart shows as a stray or doubled pulse within DELAY_CYC cycles. The cancel test therefore places the gate rise on both sides of the last cycle at which it still takes effect.

// File: rtl/vq_pkg.sv
package vq_pkg;

  // Channel positions inside the synchronizer vector.
  localparam int unsigned VQ_CH_VLY  = 0;
  localparam int unsigned VQ_CH_ARM  = 1;
  localparam int unsigned VQ_CH_GATE = 2;
  localparam int unsigned VQ_NCH     = 3;

  // Bits needed to hold the value n (at least one).
  function automatic int unsigned vq_cw(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/vq_sync.sv
module vq_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/vq_window.sv
module vq_window #(
  parameter int unsigned LEN = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);

  localparam int unsigned CW = vq_pkg::vq_cw(LEN);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)                 remain_q <= '0;
    else if (start_i)        remain_q <= CW'(LEN);
    else if (remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  assign busy_o = (remain_q != '0);

endmodule

// File: rtl/vq_delay.sv
module vq_delay #(
  parameter int unsigned DELAY = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic cancel_i,
  output logic pulse_o,
  output logic pending_o
);

  localparam int unsigned CW = vq_pkg::vq_cw(DELAY - 1);

  logic [CW-1:0] left_q;
  logic          pend_q;
  logic          pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (cancel_i) begin
        pend_q <= 1'b0;
      end else if (start_i) begin
        pend_q <= 1'b1;
        left_q <= CW'(DELAY - 1);
      end else if (pend_q) begin
        if (left_q == '0) begin
          pulse_q <= 1'b1;
          pend_q  <= 1'b0;
        end else begin
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

  assign pulse_o   = pulse_q;
  assign pending_o = pend_q;

endmodule

// File: rtl/valley_qualifier.sv
module valley_qualifier #(
  parameter int unsigned DELAY_CYC   = 25,
  parameter int unsigned MASK_CYC    = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_cmp_i,
  input  logic vly_cmp_i,
  input  logic gate_i,
  output logic valley_o
);

  import vq_pkg::*;

  logic [VQ_NCH-1:0] raw_in;
  logic [VQ_NCH-1:0] aligned;
  logic gate_lvl, arm_lvl, vly_lvl;
  logic g_prev, v_prev;
  logic g_rise, g_fall, v_fall;
  logic mask_busy, shield;
  logic armed_q, accept;
  logic dly_pending, pulse;

  // Gate goes through the same chain so windows are measured pin to pin.
  always_comb begin
    raw_in             = '0;
    raw_in[VQ_CH_VLY]  = vly_cmp_i;
    raw_in[VQ_CH_ARM]  = arm_cmp_i;
    raw_in[VQ_CH_GATE] = gate_i;
  end

  vq_sync #(
    .WIDTH (VQ_NCH),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(raw_in),
    .q_o(aligned)
  );

  assign gate_lvl = aligned[VQ_CH_GATE];
  assign arm_lvl  = aligned[VQ_CH_ARM];
  assign vly_lvl  = aligned[VQ_CH_VLY];

  always_ff @(posedge clk) begin
    if (rst) begin
      g_prev <= 1'b0;
      v_prev <= 1'b0;
    end else begin
      g_prev <= gate_lvl;
      v_prev <= vly_lvl;
    end
  end

  assign g_rise = gate_lvl & ~g_prev;
  assign g_fall = ~gate_lvl & g_prev;
  assign v_fall = ~vly_lvl & v_prev;

  vq_window #(
    .LEN(MASK_CYC)
  ) u_window (
    .clk    (clk),
    .rst    (rst),
    .start_i(g_fall),
    .busy_o (mask_busy)
  );

  // Crossings are ignored while the switch is on, at turn-off and in the window.
  assign shield = gate_lvl | g_fall | mask_busy;

  // Arming: cleared by a gate rise or any consumed crossing, set by the high flag.
  always_ff @(posedge clk) begin
    if (rst)                   armed_q <= 1'b0;
    else if (g_rise | v_fall)  armed_q <= 1'b0;
    else if (arm_lvl)          armed_q <= 1'b1;
  end

  assign accept = v_fall & armed_q & ~shield;

  vq_delay #(
    .DELAY(DELAY_CYC)
  ) u_delay (
    .clk      (clk),
    .rst      (rst),
    .start_i  (accept),
    .cancel_i (g_rise),
    .pulse_o  (pulse),
    .pending_o(dly_pending)
  );

  assign valley_o = pulse;

endmodule

// File: rtl/vq_checker.sv
module vq_checker (
  input logic clk,
  input logic rst,
  input logic valley,
  input logic gate_rise,
  input logic pending,
  input logic armed,
  input logic accept
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valley && !pending));

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    valley |=> !valley);

  // R2
  pulse_from_pending_chk: assert property (@(posedge clk) disable iff (rst)
    valley |-> $past(pending));

  // R6
  arm_consumed_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !armed);

  // R8
  cancel_kill_chk: assert property (@(posedge clk) disable iff (rst)
    gate_rise |=> (!valley && !pending));

endmodule

bind valley_qualifier vq_checker u_vq_chk (
  .clk      (clk),
  .rst      (rst),
  .valley   (valley_o),
  .gate_rise(g_rise),
  .pending  (dly_pending),
  .armed    (armed_q),
  .accept   (accept)
);

// File: tb/valley_qualifier_bench.sv
module valley_qualifier_bench;

  localparam int CLK_PERIOD = 20;
  localparam int DLY_C      = 25;
  localparam int MSK_C      = 100;
  localparam int SYN_C      = 2;
  localparam int PULSE_J    = DLY_C + SYN_C + 1;
  localparam int SPAN       = DLY_C + 8;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [15:0] gap;
    logic        armed;
    logic        hit;
  } row_t;

  localparam int NROWS = 7;
  localparam row_t ROWS [NROWS] = '{
    '{16'd1,   1'b1, 1'b0},
    '{16'd40,  1'b1, 1'b0},
    '{16'd100, 1'b1, 1'b0},
    '{16'd101, 1'b1, 1'b1},
    '{16'd160, 1'b1, 1'b1},
    '{16'd130, 1'b0, 1'b0},
    '{16'd102, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm_s = 1'b0;
  logic vly_s = 1'b0;
  logic gate_s = 1'b1;
  logic valley_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  valley_qualifier #(
    .DELAY_CYC  (DLY_C),
    .MASK_CYC   (MSK_C),
    .SYNC_STAGES(SYN_C)
  ) u_valley_qualifier (
    .clk      (clk),
    .rst      (rst),
    .arm_cmp_i(arm_s),
    .vly_cmp_i(vly_s),
    .gate_i   (gate_s),
    .valley_o (valley_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Switch on, node low, then turn off with node rising; crossing d edges later.
  task automatic fall_after(input int d, input bit arm_en);
    gate_s = 1'b1; vly_s = 1'b0; arm_s = 1'b0;
    repeat (4) @(negedge clk);
    gate_s = 1'b0; vly_s = 1'b1; arm_s = arm_en;
    repeat (d) @(negedge clk);
    vly_s = 1'b0; arm_s = 1'b0;
  endtask

  // Observe valley_o; optional gate rise and re-arm/re-fall hooks at cycle j.
  task automatic watch(input int span, input int gate_at, input int rearm_at,
                       input int refall_at, output int first, output int n);
    first = 0; n = 0;
    for (int j = 1; j <= span; j++) begin
      @(negedge clk);
      if (valley_o) begin
        n++;
        if (first == 0) first = j;
      end
      if (j == gate_at) gate_s = 1'b1;
      if (j == rearm_at) begin vly_s = 1'b1; arm_s = 1'b1; end
      if (j == refall_at) begin vly_s = 1'b0; arm_s = 1'b0; end
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, WATCHDOG - 1);
      summary();
      $finish;
    end
  end

  initial begin
    int f, n;
    // R1: quiet in reset with the valley input toggling.
    n = 0;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      vly_s = ~vly_s; arm_s = 1'b1; gate_s = 1'b0;
      if (valley_o) n++;
    end
    rst = 1'b0; gate_s = 1'b1; vly_s = 1'b0; arm_s = 1'b0;
    @(negedge clk);
    if (valley_o) n++;
    check(n == 0, "R1 reset output", n, 0);

    // R2 R3 R4: vector table of gap, arming, expected pulse.
    for (int r = 0; r < NROWS; r++) begin
      fall_after(int'(ROWS[r].gap), ROWS[r].armed);
      watch(SPAN, 0, 0, 0, f, n);
      check(n == (ROWS[r].hit ? 1 : 0), $sformatf("R2 R3 R4 row %0d pulse count", r),
            n, ROWS[r].hit ? 1 : 0);
      check(f == (ROWS[r].hit ? PULSE_J : 0), $sformatf("R2 R4 row %0d pulse cycle", r),
            f, ROWS[r].hit ? PULSE_J : 0);
    end

    // R5: armed crossing while the switch is on is ignored.
    gate_s = 1'b1; vly_s = 1'b0; arm_s = 1'b0;
    repeat (4) @(negedge clk);
    vly_s = 1'b1; arm_s = 1'b1;
    repeat (5) @(negedge clk);
    vly_s = 1'b0; arm_s = 1'b0;
    watch(SPAN, 0, 0, 0, f, n);
    check(n == 0, "R5 crossing with gate high", n, 0);

    // R6: that ignored crossing consumed the arming; unarmed crossing later.
    gate_s = 1'b0; vly_s = 1'b1;
    repeat (150) @(negedge clk);
    vly_s = 1'b0;
    watch(SPAN, 0, 0, 0, f, n);
    check(n == 0, "R6 after masked crossing", n, 0);

    // R6: accepted crossing, then an unarmed second crossing.
    fall_after(150, 1'b1);
    watch(SPAN, 0, 0, 0, f, n);
    check(n == 1 && f == PULSE_J, "R6 first accepted pulse cycle", f, PULSE_J);
    vly_s = 1'b1;
    repeat (10) @(negedge clk);
    vly_s = 1'b0;
    watch(SPAN, 0, 0, 0, f, n);
    check(n == 0, "R6 second crossing without arming", n, 0);

    // R7: arming before a gate pulse does not survive it.
    gate_s = 1'b1; vly_s = 1'b0; arm_s = 1'b0;
    repeat (4) @(negedge clk);
    gate_s = 1'b0; vly_s = 1'b1; arm_s = 1'b1;
    repeat (5) @(negedge clk);
    arm_s = 1'b0;
    repeat (3) @(negedge clk);
    gate_s = 1'b1;
    repeat (5) @(negedge clk);
    gate_s = 1'b0;
    repeat (150) @(negedge clk);
    vly_s = 1'b0;
    watch(SPAN, 0, 0, 0, f, n);
    check(n == 0, "R7 arming cleared by gate rise", n, 0);

    // R8: gate rise at V+DELAY cancels, at V+DELAY+1 it does not.
    fall_after(150, 1'b1);
    watch(SPAN, DLY_C, 0, 0, f, n);
    check(n == 0, "R8 cancel at last cycle", n, 0);
    fall_after(150, 1'b1);
    watch(SPAN, DLY_C + 1, 0, 0, f, n);
    check(n == 1 && f == PULSE_J, "R8 late gate keeps pulse", f, PULSE_J);

    // R9: second accepted crossing restarts the delay.
    fall_after(150, 1'b1);
    watch(SPAN + 10, 0, 5, 10, f, n);
    check(n == 1, "R9 single pulse after restart", n, 1);
    check(f == 10 + PULSE_J, "R9 pulse timed from second crossing", f, 10 + PULSE_J);

    // R1: reset during a pending delay discards it.
    fall_after(150, 1'b1);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    watch(SPAN, 0, 0, 0, f, n);
    check(n == 0, "R1 pending discarded by reset", n, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule